// File: doc/BRIEF.md
# Sixteen-Bit ALU with Packed Byte Lanes

This block is a stateless arithmetic logic unit for a 16-bit datapath. It takes two operands and a 4-bit operation code. Every output follows from those inputs through combinational logic only. The unit provides scalar add, subtract, three shifts, signed compare, OR and AND. It also has a packed mode that splits each operand into two independent bytes and adds, subtracts, multiplies or divides them lane by lane.

There are three flag outputs. The carry flag reports unsigned overflow. The signed-overflow flag reports two's-complement overflow for the additive operations. The equality flag compares the two operands bit for bit and does not depend on the operation code. A surrounding pipeline registers the inputs and the result as it needs to.

Top module: `alu16_core`

## Requirements
- R1: Op 4'h0 returns (a + b) mod 2^16 and op 4'h1 returns (a - b) mod 2^16.
- R2: Op 4'h2 shifts a left, filling with zeros. Op 4'h3 shifts a right, filling with zeros. Op 4'h4 shifts a right, filling with a[15]. The shift amount is b[3:0], and b[15:4] has no effect on the result.
- R3: Op 4'h5 returns 16'h0001 when a < b as signed two's-complement values, and 16'h0000 otherwise.
- R4: Op 4'h6 returns a | b and op 4'h7 returns a & b.
- R5: uovf_o is high only for op 4'h0 with a carry out of bit 15, or for op 4'h8+2 (4'hA) with a carry out of either byte lane. It is low for every other op, subtract included.
- R6: sovf_o is high for op 4'h0 or 4'h1 when the 16-bit signed result overflows. It is also high for op 4'hA or 4'hB when either byte lane overflows as a signed value. It is low for all other ops.
- R7: Op 4'hA adds lane by lane and op 4'hB subtracts lane by lane. The lanes are bits [15:8] and [7:0], and no carry or borrow passes from the low lane into the high lane.
- R8: Op 4'h8 returns, in each lane, the low 8 bits of the unsigned product of the two lane operands.
- R9: Op 4'h9 returns, in each lane, the unsigned quotient of the two lane operands. A lane whose divisor is zero returns 8'hFF.
- R10: eq_o is high exactly when a equals b, for every value of op.
- R11: Ops 4'hC to 4'hF return 16'h0000 with uovf_o and sovf_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand; bits [3:0] give the shift amount |
| op_i | input | 4 | Operation code |
| res_o | output | 16 | Result |
| uovf_o | output | 1 | Unsigned overflow (carry) flag |
| sovf_o | output | 1 | Signed overflow flag |
| eq_o | output | 1 | Operands are bit-identical |

## Verification
The checker evaluates its assertions whenever the inputs change. They check that each overflow flag rises only for the operation codes that own it, and that reserved codes give a zero result with both flags clear. They also check that compare results are 0 or 1, that a divisor-zero lane reads all ones, and that the equality flag agrees with a zero difference on subtract. The exact arithmetic values need the bench's scenarios to show them: no carry crossing between lanes, truncated products, shift fill and the upper shift bits having no effect. The bench checks these against a table of hand-worked vectors and against a model of its own run over random operands.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_SLL  = 4'h2,
    OP_SRL  = 4'h3,
    OP_SRA  = 4'h4,
    OP_SLT  = 4'h5,
    OP_OR   = 4'h6,
    OP_AND  = 4'h7,
    OP_PMUL = 4'h8,
    OP_PDIV = 4'h9,
    OP_PADD = 4'hA,
    OP_PSUB = 4'hB
  } alu_op_e;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] diff_o,
  output logic              carry_o,
  output logic              add_sovf_o,
  output logic              sub_sovf_o,
  output logic              slt_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0] sum_ext;
  logic [DATA_W:0] diff_ext;

  assign sum_ext  = {1'b0, a_i} + {1'b0, b_i};
  assign diff_ext = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};

  assign sum_o   = sum_ext[DATA_W-1:0];
  assign diff_o  = diff_ext[DATA_W-1:0];
  assign carry_o = sum_ext[DATA_W];

  assign add_sovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
  assign sub_sovf_o = (a_i[MSB] != b_i[MSB]) && (diff_o[MSB] != a_i[MSB]);

  // signed less-than from the subtractor: sign corrected by overflow
  assign slt_o = diff_o[MSB] ^ sub_sovf_o;
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0]         a_i,
  input  logic [$clog2(DATA_W)-1:0] shamt_i,
  input  logic                      left_i,
  input  logic                      arith_i,
  output logic [DATA_W-1:0]         res_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] a_rev;
  logic [DATA_W-1:0] out_rev;
  logic [DATA_W-1:0] stg [SH_W+1];
  logic              fill;

  // one right shifter; left shifts go through a bit reversal on each side
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign a_rev[i]   = a_i[DATA_W-1-i];
    assign out_rev[i] = stg[SH_W][DATA_W-1-i];
  end

  assign fill   = arith_i & ~left_i & a_i[DATA_W-1];
  assign stg[0] = left_i ? a_rev : a_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stg[k+1] = shamt_i[k] ? {{STEP{fill}}, stg[k][DATA_W-1:STEP]} : stg[k];
  end

  assign res_o = left_i ? out_rev : stg[SH_W];
endmodule

// File: rtl/alu16_lanes.sv
module alu16_lanes #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] add_o,
  output logic [DATA_W-1:0] sub_o,
  output logic [DATA_W-1:0] mul_o,
  output logic [DATA_W-1:0] div_o,
  output logic              add_carry_o,
  output logic              add_sovf_o,
  output logic              sub_sovf_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned MSB   = LANE_W - 1;

  logic [LANES-1:0] carry_l;
  logic [LANES-1:0] add_ov_l;
  logic [LANES-1:0] sub_ov_l;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] la, lb, ls, ld, lm, lq;
    logic [LANE_W:0]   s_ext;

    assign la    = a_i[l*LANE_W +: LANE_W];
    assign lb    = b_i[l*LANE_W +: LANE_W];
    assign s_ext = {1'b0, la} + {1'b0, lb};
    assign ls    = s_ext[LANE_W-1:0];
    assign ld    = la - lb;
    assign lm    = la * lb;
    assign lq    = (lb == '0) ? '1 : la / lb;

    assign carry_l[l]  = s_ext[LANE_W];
    assign add_ov_l[l] = (la[MSB] == lb[MSB]) && (ls[MSB] != la[MSB]);
    assign sub_ov_l[l] = (la[MSB] != lb[MSB]) && (ld[MSB] != la[MSB]);

    assign add_o[l*LANE_W +: LANE_W] = ls;
    assign sub_o[l*LANE_W +: LANE_W] = ld;
    assign mul_o[l*LANE_W +: LANE_W] = lm;
    assign div_o[l*LANE_W +: LANE_W] = lq;
  end

  assign add_carry_o = |carry_l;
  assign add_sovf_o  = |add_ov_l;
  assign sub_sovf_o  = |sub_ov_l;
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int unsigned DATA_W = alu16_pkg::DATA_W,
  parameter int unsigned LANE_W = alu16_pkg::LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              uovf_o,
  output logic              sovf_o,
  output logic              eq_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sum, diff, shifted;
  logic [DATA_W-1:0] p_add, p_sub, p_mul, p_div;
  logic              carry, add_sovf, sub_sovf, slt;
  logic              p_carry, p_add_sovf, p_sub_sovf;

  alu16_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i        (a_i),
    .b_i        (b_i),
    .sum_o      (sum),
    .diff_o     (diff),
    .carry_o    (carry),
    .add_sovf_o (add_sovf),
    .sub_sovf_o (sub_sovf),
    .slt_o      (slt)
  );

  alu16_shift #(.DATA_W(DATA_W)) u_shift (
    .a_i     (a_i),
    .shamt_i (b_i[SH_W-1:0]),
    .left_i  (op_i == OP_SLL),
    .arith_i (op_i == OP_SRA),
    .res_o   (shifted)
  );

  alu16_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes (
    .a_i         (a_i),
    .b_i         (b_i),
    .add_o       (p_add),
    .sub_o       (p_sub),
    .mul_o       (p_mul),
    .div_o       (p_div),
    .add_carry_o (p_carry),
    .add_sovf_o  (p_add_sovf),
    .sub_sovf_o  (p_sub_sovf)
  );

  always_comb begin
    res_o  = '0;
    uovf_o = 1'b0;
    sovf_o = 1'b0;
    case (op_i)
      OP_ADD:  begin res_o = sum;  uovf_o = carry; sovf_o = add_sovf; end
      OP_SUB:  begin res_o = diff; sovf_o = sub_sovf; end
      OP_SLL, OP_SRL, OP_SRA: res_o = shifted;
      OP_SLT:  res_o = {{(DATA_W-1){1'b0}}, slt};
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_PMUL: res_o = p_mul;
      OP_PDIV: res_o = p_div;
      OP_PADD: begin res_o = p_add; uovf_o = p_carry; sovf_o = p_add_sovf; end
      OP_PSUB: begin res_o = p_sub; sovf_o = p_sub_sovf; end
      default: ;
    endcase
  end

  assign eq_o = (a_i == b_i);
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk
  import alu16_pkg::*;
#(
  parameter int unsigned DATA_W = alu16_pkg::DATA_W,
  parameter int unsigned LANE_W = alu16_pkg::LANE_W
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] res_o,
  input logic              uovf_o,
  input logic              sovf_o,
  input logic              eq_o
);
  always_comb begin
    AST_UOVF_CLASS: assert (!uovf_o || op_i == OP_ADD || op_i == OP_PADD); // R5
    AST_SOVF_CLASS: assert (!sovf_o || op_i == OP_ADD || op_i == OP_SUB ||
                            op_i == OP_PADD || op_i == OP_PSUB); // R6
    AST_RSVD_ZERO: assert (op_i < 4'hC || (res_o == '0 && !uovf_o && !sovf_o)); // R11
    AST_SLT_BOOL: assert (op_i != OP_SLT || res_o[DATA_W-1:1] == '0); // R3
    AST_EQ_SUB_ZERO: assert (op_i != OP_SUB || eq_o == (res_o == '0)); // R10
    AST_PDIV_LO_ZERO: assert (op_i != OP_PDIV || b_i[LANE_W-1:0] != '0 ||
                              res_o[LANE_W-1:0] == '1); // R9
    AST_PDIV_HI_ZERO: assert (op_i != OP_PDIV || b_i[DATA_W-1 -: LANE_W] != '0 ||
                              res_o[DATA_W-1 -: LANE_W] == '1); // R9
  end
endmodule

bind alu16_core alu16_core_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .op_i   (op_i),
  .res_o  (res_o),
  .uovf_o (uovf_o),
  .sovf_o (sovf_o),
  .eq_o   (eq_o)
);

// File: tb/alu16_core_tb.sv
module alu16_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 22;
  localparam int N_RAND     = 3000;
  localparam int WDOG_LIMIT = 100000;

  logic        clk = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [3:0]  op_i = '0;
  logic [15:0] res_o;
  logic        uovf_o, sovf_o, eq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  alu16_core u_dut (
    .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .res_o(res_o), .uovf_o(uovf_o), .sovf_o(sovf_o), .eq_o(eq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG_LIMIT) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // {op, a, b, res, uovf, sovf, eq}
  localparam logic [54:0] VEC [N_VEC] = '{
    {4'h0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0, 1'b0},
    {4'h0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1, 1'b0},
    {4'h1, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 1'b1, 1'b0},
    {4'h1, 16'h0001, 16'h0002, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    {4'h2, 16'h0001, 16'hFFF4, 16'h0010, 1'b0, 1'b0, 1'b0},
    {4'h3, 16'h8000, 16'h000F, 16'h0001, 1'b0, 1'b0, 1'b0},
    {4'h4, 16'h8000, 16'h0013, 16'hF000, 1'b0, 1'b0, 1'b0},
    {4'h5, 16'hFFFF, 16'h0001, 16'h0001, 1'b0, 1'b0, 1'b0},
    {4'h5, 16'h0001, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0},
    {4'h6, 16'h0F0F, 16'h3030, 16'h3F3F, 1'b0, 1'b0, 1'b0},
    {4'h7, 16'h0FF0, 16'h3C3C, 16'h0C30, 1'b0, 1'b0, 1'b0},
    {4'h8, 16'h1003, 16'h2005, 16'h000F, 1'b0, 1'b0, 1'b0},
    {4'h8, 16'hFF02, 16'h0203, 16'hFE06, 1'b0, 1'b0, 1'b0},
    {4'h9, 16'h6407, 16'h0A00, 16'h0AFF, 1'b0, 1'b0, 1'b0},
    {4'h9, 16'hFF80, 16'h0280, 16'h7F01, 1'b0, 1'b0, 1'b0},
    {4'hA, 16'h80FF, 16'h8001, 16'h0000, 1'b1, 1'b1, 1'b0},
    {4'hA, 16'h017F, 16'h0101, 16'h0280, 1'b0, 1'b1, 1'b0},
    {4'hA, 16'h10F0, 16'h1020, 16'h2010, 1'b1, 1'b0, 1'b0},
    {4'hB, 16'h0080, 16'h0001, 16'h007F, 1'b0, 1'b1, 1'b0},
    {4'hB, 16'h0100, 16'h0001, 16'h01FF, 1'b0, 1'b0, 1'b0},
    {4'hC, 16'h1234, 16'h1234, 16'h0000, 1'b0, 1'b0, 1'b1},
    {4'hF, 16'hFFFF, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0:  return "R1/R5";
      1:  return "R1/R6";
      2:  return "R6";
      3:  return "R5";
      4, 5, 6: return "R2";
      7, 8: return "R3";
      9, 10: return "R4";
      11, 12: return "R8";
      13, 14: return "R9";
      15, 16, 17, 18, 19: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic string op_tag(logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R1";
      4'h2, 4'h3, 4'h4: return "R2";
      4'h5: return "R3";
      4'h6, 4'h7: return "R4";
      4'h8: return "R8";
      4'h9: return "R9";
      4'hA, 4'hB: return "R7";
      default: return "R11";
    endcase
  endfunction

  // independent model: {res, uovf, sovf, eq}
  function automatic logic [18:0] model(logic [3:0] op, logic [15:0] a, logic [15:0] b);
    int ua = int'(a), ub = int'(b);
    int sa = (ua >= 32768) ? ua - 65536 : ua;
    int sb = (ub >= 32768) ? ub - 65536 : ub;
    int sh = int'(b[3:0]);
    int t;
    logic [15:0] r = '0;
    logic uo = 1'b0, so = 1'b0;
    case (op)
      4'h0: begin t = ua + ub; r = 16'(t); uo = (t > 65535);
                  so = (sa + sb > 32767) || (sa + sb < -32768); end
      4'h1: begin r = 16'(ua - ub); so = (sa - sb > 32767) || (sa - sb < -32768); end
      4'h2: r = 16'((ua * (1 << sh)) % 65536);
      4'h3: r = 16'(ua / (1 << sh));
      4'h4: begin t = sa; for (int k = 0; k < sh; k++) t = (t < 0) ? (t - 1) / 2 : t / 2;
                  r = 16'(t); end
      4'h5: r = (sa < sb) ? 16'd1 : 16'd0;
      4'h6: for (int k = 0; k < 16; k++) r[k] = a[k] | b[k];
      4'h7: for (int k = 0; k < 16; k++) r[k] = a[k] & b[k];
      4'h8, 4'h9, 4'hA, 4'hB: begin
        for (int l = 0; l < 2; l++) begin
          int x = int'(a[l*8 +: 8]);
          int y = int'(b[l*8 +: 8]);
          int sx = (x >= 128) ? x - 256 : x;
          int sy = (y >= 128) ? y - 256 : y;
          int v;
          case (op)
            4'h8: v = (x * y) % 256;
            4'h9: v = (y == 0) ? 255 : x / y;
            4'hA: begin v = (x + y) % 256; uo |= (x + y > 255);
                        so |= (sx + sy > 127) || (sx + sy < -128); end
            default: begin v = (x - y + 256) % 256;
                        so |= (sx - sy > 127) || (sx - sy < -128); end
          endcase
          r[l*8 +: 8] = 8'(v);
        end
      end
      default: ;
    endcase
    return {r, uo, so, (ua == ub)};
  endfunction

  task automatic apply(logic [3:0] op, logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b;
    #1;
  endtask

  task automatic check(string tag, logic [18:0] exp);
    n_tests++;
    if ({res_o, uovf_o, sovf_o, eq_o} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h a=%h b=%h: actual res=%h u=%b s=%b eq=%b expected res=%h u=%b s=%b eq=%b",
               tag, op_i, a_i, b_i, res_o, uovf_o, sovf_o, eq_o,
               exp[18:3], exp[2], exp[1], exp[0]);
    end
  endtask

  initial begin
    // idle inputs: zero result, equal operands (R1, R10)
    apply(4'h0, 16'h0000, 16'h0000);
    check("R10", {16'h0000, 1'b0, 1'b0, 1'b1});

    for (int i = 0; i < N_VEC; i++) begin
      logic [54:0] v = VEC[i];
      apply(v[54:51], v[50:35], v[34:19]);
      check(vec_tag(i), v[18:0]);
    end

    // R10: equality under every op code
    for (int op = 0; op < 16; op++) begin
      apply(4'(op), 16'hABCD, 16'hABCD);
      n_tests++;
      if (eq_o !== 1'b1) begin
        n_fail++;
        $display("FAIL R10 op=%h: actual eq=%b expected eq=1", op, eq_o);
      end
    end

    // R2: upper shift bits have no effect
    for (int sh = 0; sh < 16; sh++) begin
      for (int op = 2; op <= 4; op++) begin
        logic [15:0] ref_res;
        apply(4'(op), 16'hB3C5, {12'h000, 4'(sh)});
        ref_res = res_o;
        apply(4'(op), 16'hB3C5, {12'hA5F, 4'(sh)});
        n_tests++;
        if (res_o !== ref_res) begin
          n_fail++;
          $display("FAIL R2 op=%h sh=%0d: actual %h expected %h", op, sh, res_o, ref_res);
        end
      end
    end

    for (int n = 0; n < N_RAND; n++) begin
      logic [3:0]  op = 4'($urandom_range(0, 15));
      logic [15:0] a  = 16'($urandom);
      logic [15:0] b  = 16'($urandom);
      if (n % 7 == 0) b[7:0] = 8'h00;
      if (n % 11 == 0) b = a;
      apply(op, a, b);
      check(op_tag(op), model(op, a, b));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule